// File: doc/BRIEF.md
# DMA Request Routing Channel Bank

This block sits between a set of peripheral request lines and a DMA controller. It holds a bank of routing channels. Each channel selects one request input by an 8-bit identifier and passes it to its own output towards one DMA controller channel. Forwarding is framed by a per-channel synchronization input. A synchronization pulse opens a window, and the window closes once a programmed number of requests has been forwarded. A synchronization pulse that arrives while a window is still incomplete is an overrun. The overrun is recorded in a sticky flag and can raise an interrupt.

Software programs each channel through a word-addressed configuration register. Channel c sits at byte offset 4*c. The word holds the request identifier, the overrun interrupt enable, the event enable and the request count minus one. The overrun flags of all channels are read from a read-only status word. They are cleared through a separate write-one-to-clear register. When event generation is enabled, a channel emits a one-cycle event pulse as each window completes.

Top module: `reqRouteBank`

## Requirements
- R1: After reset all configuration words, overrun flags and the outputs `reqOut`, `evtOut` and `irqOut` are zero. Reads of the status word and of every configuration word return zero.
- R2: A write to byte offset 4*c sets channel c's configuration from the next cycle. The request identifier is in bits 7:0. While the window of channel c is open, `reqOut[c]` equals `reqIn[identifier]` in the same cycle.
- R3: An identifier of `NUM_IN` or above makes the channel forward a constant low, whatever `reqIn` holds.
- R4: The request count minus one is in config bits 23:19. A high `syncIn[c]` opens channel c's window and reloads its counter to zero, and nothing is forwarded in that cycle. Each cycle with `reqOut[c]` high counts one request. The window closes after the request that makes the count equal to the field plus one. While closed, `reqOut[c]` is low.
- R5: When config bit 9 is 1, `evtOut[c]` is high for exactly the one cycle after the completing request. When bit 9 is 0, it stays low.
- R6: A high `syncIn[c]` while channel c's window is open sets the overrun flag of channel c. The flag appears as bit c of the status word at byte offset 0x080 from the next cycle. A sync while the window is closed sets nothing.
- R7: Writing the clear register at byte offset 0x084 clears each flag whose data bit is 1. Data bits at 0 leave their flags unchanged. When a set and a clear hit the same flag in one cycle, the flag ends set.
- R8: `irqOut` is the OR over all channels of the overrun flag ANDed with config bit 8.
- R9: Status bits 31:14 read zero. The clear register reads zero. A configuration word reads back only bits 9:0 and 23:19, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Byte address of the register access |
| regWrEn | input | 1 | Write strobe for the current cycle |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| reqIn | input | NUM_IN | Peripheral request inputs |
| syncIn | input | 14 | Per-channel synchronization pulses |
| reqOut | output | 14 | Forwarded requests, one per channel |
| evtOut | output | 14 | Window completion event pulses |
| irqOut | output | 1 | Combined overrun interrupt |

## Verification
Two things can meet on one flag in the same cycle: a clear write to 0x084 and a synchronization pulse that sets the flag because it lands on an open window. The bench forces this meeting directly. It opens a window on one channel, then in a single cycle sends the next sync pulse together with a clear write on that channel's bit, and expects the flag to read set. Random traffic mixes sparse sync pulses, dense requests and random clear masks, so that the same collision recurs across channels. A bench model that applies the set-over-clear rule judges every cycle of status and interrupt.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
  parameter int NUM_CH = 14;
  parameter int ID_W   = 8;
  parameter int CNT_W  = 5;
  parameter int ADDR_W = 8;
  parameter int DATA_W = 32;

  localparam int IE_BIT  = ID_W;
  localparam int EV_BIT  = ID_W + 1;
  localparam int CNT_LSB = 19;
  localparam logic [ADDR_W-1:0] STAT_OFF = ADDR_W'(8'h80);
  localparam logic [ADDR_W-1:0] CLR_OFF  = ADDR_W'(8'h84);

  typedef struct packed {
    logic [CNT_W-1:0] cntM1;
    logic             evtEn;
    logic             ovrIe;
    logic [ID_W-1:0]  reqId;
  } chanCfg_t;

  typedef struct packed {
    logic [NUM_CH-1:0] cfgWr;
    logic [NUM_CH-1:0] clrFlag;
  } ctrlStrobe_t;
endpackage

// File: rtl/rrb_chan.sv
module rrb_chan
  import rrb_pkg::*;
#(
  parameter int NUM_IN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanCfg_t          cfg,
  input  logic [NUM_IN-1:0] reqIn,
  input  logic              syncIn,
  input  logic              clrFlag,
  output logic              reqOut,
  output logic              evtOut,
  output logic              flag
);
  logic             selReq;
  logic             winOpen;
  logic             done;
  logic             ovrSet;
  logic [CNT_W-1:0] cnt;

  // identifiers past the implemented inputs match nothing and select low
  always_comb begin
    selReq = 1'b0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (int'(cfg.reqId) == i) selReq = reqIn[i];
    end
  end

  assign reqOut = winOpen & selReq & ~syncIn;
  assign done   = reqOut && (cnt == cfg.cntM1);
  assign ovrSet = syncIn & winOpen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winOpen <= 1'b0;
      cnt     <= '0;
      evtOut  <= 1'b0;
      flag    <= 1'b0;
    end else begin
      if (syncIn) begin
        winOpen <= 1'b1;
        cnt     <= '0;
      end else if (reqOut) begin
        cnt <= cnt + 1'b1;
        if (done) winOpen <= 1'b0;
      end
      evtOut <= done & cfg.evtEn;
      flag   <= ovrSet | (flag & ~clrFlag);
    end
  end

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    evtOut |=> !evtOut); // R5
  AST_EVT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.evtEn |=> !evtOut); // R5
  AST_CLOSE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !reqOut); // R4
  AST_BAD_ID_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (int'(cfg.reqId) >= NUM_IN) |-> !reqOut); // R3
  AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (syncIn && winOpen) |=> flag); // R6
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (clrFlag && !(syncIn && winOpen)) |=> !flag); // R7
endmodule

// File: rtl/rrb_path.sv
module rrb_path
  import rrb_pkg::*;
#(
  parameter int NUM_IN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_IN-1:0] reqIn,
  input  logic [NUM_CH-1:0] syncIn,
  output logic [NUM_CH-1:0] reqOut,
  output logic [NUM_CH-1:0] evtOut,
  output logic [NUM_CH-1:0] flags,
  output chanCfg_t          cfgQ [NUM_CH],
  output logic              irqOut
);
  chanCfg_t          cfgNew;
  logic [NUM_CH-1:0] ieVec;

  assign cfgNew.reqId = wrData[ID_W-1:0];
  assign cfgNew.ovrIe = wrData[IE_BIT];
  assign cfgNew.evtEn = wrData[EV_BIT];
  assign cfgNew.cntM1 = wrData[CNT_LSB +: CNT_W];

  for (genvar c = 0; c < NUM_CH; c++) begin : gChan
    always_ff @(posedge clk) begin
      if (!rstN) cfgQ[c] <= '0;
      else if (strobe.cfgWr[c]) cfgQ[c] <= cfgNew;
    end

    assign ieVec[c] = cfgQ[c].ovrIe;

    rrb_chan #(.NUM_IN(NUM_IN)) uChan (
      .clk    (clk),
      .rstN   (rstN),
      .cfg    (cfgQ[c]),
      .reqIn  (reqIn),
      .syncIn (syncIn[c]),
      .clrFlag(strobe.clrFlag[c]),
      .reqOut (reqOut[c]),
      .evtOut (evtOut[c]),
      .flag   (flags[c])
    );
  end

  assign irqOut = |(flags & ieVec);

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (flags != '0)); // R8
endmodule

// File: rtl/rrb_ctrl.sv
module rrb_ctrl
  import rrb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [NUM_CH-1:0] flags,
  input  chanCfg_t          cfgQ [NUM_CH],
  output ctrlStrobe_t       strobe,
  output logic [DATA_W-1:0] regRdData
);
  function automatic logic [DATA_W-1:0] packCfg(input chanCfg_t c);
    logic [DATA_W-1:0] w;
    w                      = '0;
    w[ID_W-1:0]            = c.reqId;
    w[IE_BIT]              = c.ovrIe;
    w[EV_BIT]              = c.evtEn;
    w[CNT_LSB +: CNT_W]    = c.cntM1;
    return w;
  endfunction

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      strobe.cfgWr[c] = regWrEn && (regAddr == ADDR_W'(4 * c));
    end
    strobe.clrFlag = (regWrEn && regAddr == CLR_OFF) ? regWrData[NUM_CH-1:0] : '0;
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == STAT_OFF) regRdData = DATA_W'(flags);
    for (int c = 0; c < NUM_CH; c++) begin
      if (regAddr == ADDR_W'(4 * c)) regRdData = packCfg(cfgQ[c]);
    end
  end

  AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == STAT_OFF) |-> (regRdData[DATA_W-1:NUM_CH] == '0)); // R9
  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == CLR_OFF) |-> (regRdData == '0)); // R9
endmodule

// File: rtl/reqRouteBank.sv
module reqRouteBank
  import rrb_pkg::*;
#(
  parameter int NUM_IN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [NUM_IN-1:0] reqIn,
  input  logic [NUM_CH-1:0] syncIn,
  output logic [NUM_CH-1:0] reqOut,
  output logic [NUM_CH-1:0] evtOut,
  output logic              irqOut
);
  ctrlStrobe_t       strobe;
  chanCfg_t          cfgQ [NUM_CH];
  logic [NUM_CH-1:0] flags;

  rrb_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .flags    (flags),
    .cfgQ     (cfgQ),
    .strobe   (strobe),
    .regRdData(regRdData)
  );

  rrb_path #(.NUM_IN(NUM_IN)) uPath (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrData(regWrData),
    .reqIn (reqIn),
    .syncIn(syncIn),
    .reqOut(reqOut),
    .evtOut(evtOut),
    .flags (flags),
    .cfgQ  (cfgQ),
    .irqOut(irqOut)
  );
endmodule

// File: tb/test_reqRouteBank.sv
module test_reqRouteBank;
  localparam int NIN = 64;
  localparam int NCH = 14;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [7:0]      regAddr = '0;
  logic            regWrEn = 1'b0;
  logic [31:0]     regWrData = '0;
  logic [31:0]     regRdData;
  logic [NIN-1:0]  reqIn = '0;
  logic [NCH-1:0]  syncIn = '0;
  logic [NCH-1:0]  reqOut;
  logic [NCH-1:0]  evtOut;
  logic            irqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  bit mWin [NCH];
  int mCnt [NCH];
  bit mFlag[NCH];
  bit mEvt [NCH];
  int cId  [NCH];
  bit cIe  [NCH];
  bit cEv  [NCH];
  int cCnt [NCH];

  always #5 clk = ~clk;

  reqRouteBank #(.NUM_IN(NIN)) i_reqRouteBank (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .reqIn(reqIn),
    .syncIn(syncIn), .reqOut(reqOut), .evtOut(evtOut), .irqOut(irqOut)
  );

  function automatic logic [31:0] cfgWord(int id, bit ie, bit ev, int cnt);
    return (32'(id) & 32'hFF) | (32'(ie) << 8) | (32'(ev) << 9) | ((32'(cnt) & 32'h1F) << 19);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=0x%0h exp=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [NIN-1:0] rq, input logic [NCH-1:0] sy,
                      input bit wr, input logic [7:0] ad, input logic [31:0] wd);
    logic [NCH-1:0] eReq, eEvt, eStat;
    bit eIrq;
    @(negedge clk);
    reqIn = rq; syncIn = sy; regWrEn = wr; regAddr = ad; regWrData = wd;
    #1;
    eIrq = 0;
    for (int c = 0; c < NCH; c++) begin
      bit sel;
      sel = (cId[c] < NIN) ? rq[cId[c]] : 1'b0;
      eReq[c]  = mWin[c] && sel && !sy[c];
      eEvt[c]  = mEvt[c];
      eStat[c] = mFlag[c];
      if (mFlag[c] && cIe[c]) eIrq = 1;
    end
    chk(reqOut == eReq, "R4 reqOut", 32'(reqOut), 32'(eReq));
    chk(evtOut == eEvt, "R5 evtOut", 32'(evtOut), 32'(eEvt));
    chk(irqOut == eIrq, "R8 irqOut", 32'(irqOut), 32'(eIrq));
    if (!wr && ad == 8'h80) chk(regRdData == 32'(eStat), "R6 status", regRdData, 32'(eStat));
    for (int c = 0; c < NCH; c++) begin
      bit ovr, done, clr;
      done = eReq[c] && (mCnt[c] == cCnt[c]);
      ovr  = sy[c] && mWin[c];
      if (sy[c]) begin
        mWin[c] = 1; mCnt[c] = 0;
      end else if (eReq[c]) begin
        mCnt[c] = (mCnt[c] + 1) % 32;
        if (done) mWin[c] = 0;
      end
      mEvt[c]  = done && cEv[c];
      clr      = wr && ad == 8'h84 && wd[c];
      mFlag[c] = ovr || (mFlag[c] && !clr);
      if (wr && ad == 8'(4 * c)) begin
        cId[c] = int'(wd[7:0]); cIe[c] = wd[8]; cEv[c] = wd[9]; cCnt[c] = int'(wd[23:19]);
      end
    end
  endtask

  task automatic idle(input logic [7:0] ad);
    step('0, '0, 0, ad, '0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NCH; c++) begin
      mWin[c] = 0; mCnt[c] = 0; mFlag[c] = 0; mEvt[c] = 0;
      cId[c] = 0; cIe[c] = 0; cEv[c] = 0; cCnt[c] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(reqOut == '0 && evtOut == '0 && irqOut == 1'b0, "R1 outputs in reset",
        {reqOut, evtOut, 3'b0, irqOut}, 32'h0);
    @(negedge clk); rstN = 1'b1;

    idle(8'h80);
    chk(regRdData == 32'h0, "R1 status after reset", regRdData, 32'h0);
    idle(8'h00);
    chk(regRdData == 32'h0, "R1 config after reset", regRdData, 32'h0);

    // channel 0: id 5, three requests per window, event and interrupt on
    step('0, '0, 1, 8'h00, cfgWord(5, 1, 1, 2));
    step('0, '0, 1, 8'h08, 32'hFFFF_FFFF);
    idle(8'h00);
    chk(regRdData == cfgWord(5, 1, 1, 2), "R9 config readback", regRdData, cfgWord(5, 1, 1, 2));
    idle(8'h08);
    chk(regRdData == 32'h00F8_03FF, "R9 config masked", regRdData, 32'h00F8_03FF);
    idle(8'h84);
    chk(regRdData == 32'h0, "R9 clear reads zero", regRdData, 32'h0);

    step(64'h20, '0, 0, 8'h80, '0);
    chk(reqOut[0] == 1'b0, "R4 closed window blocks", 32'(reqOut[0]), 32'h0);
    step(64'h20, 14'h1, 0, 8'h80, '0);
    chk(reqOut[0] == 1'b0, "R4 sync cycle forwards nothing", 32'(reqOut[0]), 32'h0);
    step(64'h20, '0, 0, 8'h80, '0);
    chk(reqOut[0] == 1'b1, "R2 routed request", 32'(reqOut[0]), 32'h1);
    step(64'h20, '0, 0, 8'h80, '0);
    step(64'h20, '0, 0, 8'h80, '0);
    step(64'h20, '0, 0, 8'h80, '0);
    chk(evtOut[0] == 1'b1 && reqOut[0] == 1'b0, "R5 event after last request",
        {30'h0, evtOut[0], reqOut[0]}, 32'h2);
    idle(8'h80);
    chk(evtOut[0] == 1'b0, "R5 event one cycle", 32'(evtOut[0]), 32'h0);

    // overrun on channel 0
    step('0, 14'h1, 0, 8'h80, '0);
    step(64'h20, '0, 0, 8'h80, '0);
    step('0, 14'h1, 0, 8'h80, '0);
    idle(8'h80);
    chk(regRdData[0] == 1'b1 && irqOut, "R6 overrun flag", {30'h0, irqOut, regRdData[0]}, 32'h3);
    step('0, '0, 1, 8'h84, 32'h0000_3FFE);
    idle(8'h80);
    chk(regRdData[0] == 1'b1, "R7 zero bit keeps flag", 32'(regRdData[0]), 32'h1);
    step('0, '0, 1, 8'h84, 32'h1);
    idle(8'h80);
    chk(regRdData[0] == 1'b0 && !irqOut, "R7 clear by one", {30'h0, irqOut, regRdData[0]}, 32'h0);
    // collision: window still open, sync and clear in one cycle
    step('0, 14'h1, 1, 8'h84, 32'h1);
    idle(8'h80);
    chk(regRdData[0] == 1'b1, "R7 set wins over clear", 32'(regRdData[0]), 32'h1);
    step('0, '0, 1, 8'h00, cfgWord(5, 0, 1, 2));
    idle(8'h80);
    chk(irqOut == 1'b0, "R8 enable off masks irq", 32'(irqOut), 32'h0);

    // channel 2 holds id 255: beyond the inputs
    step('1, 14'h4, 0, 8'h80, '0);
    step('1, '0, 0, 8'h80, '0);
    chk(reqOut[2] == 1'b0, "R3 out-of-range id low", 32'(reqOut[2]), 32'h0);

    for (int c = 0; c < NCH; c++)
      step('0, '0, 1, 8'(4 * c), cfgWord($urandom_range(0, 79), $urandom_range(0, 1),
                                         $urandom_range(0, 1), $urandom_range(0, 3)));
    for (int n = 0; n < 4000; n++) begin
      logic [NIN-1:0] rq;
      logic [NCH-1:0] sy;
      int r;
      rq = {$urandom(), $urandom()} | {$urandom(), $urandom()};
      sy = '0;
      for (int c = 0; c < NCH; c++) sy[c] = ($urandom_range(0, 11) == 0);
      r = $urandom_range(0, 39);
      if (r < 4)
        step(rq, sy, 1, 8'h84, 32'($urandom()));
      else if (r == 4)
        step(rq, sy, 1, 8'(4 * $urandom_range(0, NCH - 1)),
             cfgWord($urandom_range(0, 79), $urandom_range(0, 1),
                     $urandom_range(0, 1), $urandom_range(0, 3)));
      else
        step(rq, sy, 0, 8'h80, '0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule